// File: doc/BRIEF.md
# LED Flash Pattern Generator

This block drives the on/off pattern of one LED current-sink channel. A period counter advances on a slow clock-enable tick, which stands for a 32 kHz time base, and returns to zero after a programmable number of ticks. Within each period up to four pulses may be lit. Each pulse has its own start count and its own enable bit, and all four share one on-time. The block outputs a pulse-active flag, which is the OR of every enabled pulse window, and a 3-bit sink-current code.

Configuration arrives through a plain parallel write port that a separate register-interface block drives. Period, on-time, start and enable writes go into shadow registers and are copied into the running set only when the counter wraps. This keeps every period whole. The current code is different: it takes effect on the next clock without disturbing the pattern. A period of zero turns the pattern off.

Top module: `led_flash_gen`

## Requirements
- R1: After reset the pulse flag is 0 and the current code is 7. All configuration (period, on-time, enables, starts) is 0, so the pattern is disabled.
- R2: The counter moves only on a clock where `tick_i` is 1. With running period P > 0 it counts 0, 1, ..., P-1 and then returns to 0, so one period lasts P ticks.
- R3: Pulse i is lit while its running enable is 1 and start_i <= count < start_i + on_time. `pulse_on_o` is the OR of all four windows and reflects the count registered at the last tick.
- R4: A pulse whose enable bit is 0 never sets `pulse_on_o`, even when the count lies inside its window.
- R5: A window that reaches past P-1 is cut off at the wrap. It does not light count 0 of the next period.
- R6: Writes to the period, on-time, enable mask or start registers do not change the running pattern. They are copied into the running set on the tick that wraps the counter. While the running period is 0, they are copied on any tick, and that tick leaves the count at 0.
- R7: While the running period is 0, `pulse_on_o` is 0 and the count stays at 0.
- R8: A write to the current-code register changes `cur_code_o` on the next clock and leaves the count and the pattern unchanged. Code c selects (c+1)×3 mA, so code 7 is 24 mA.
- R9: The address map is fixed. 0 holds the period in data[7:0]. 1 holds the on-time in data[7:0]. 2 holds the enable mask in data[3:0], where bit i enables pulse i. 3 holds the current code in data[2:0]. 4+i holds the start of pulse i in data[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time-base clock enable, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| pulse_on_o | output | 1 | LED pulse active |
| cur_code_o | output | 3 | Sink-current code |

## Verification
The assertions check these properties on every clock:
- the count holds when there is no tick;
- the count stays below a non-zero running period;
- the running configuration changes only on a load;
- a zero period keeps the output dark;
- the output is lit only when some enabled window covers the count;
- a code write shows up on the next clock.

Only the bench scenarios can show the following:
- the exact pulse sequence across a period;
- the cut-off of a window at the wrap;
- a disabled pulse left dark inside its window;
- a pending on-time and period taking hold exactly at the wrap;
- restart from a zero period.

// File: rtl/led_flash_pkg.sv
package led_flash_pkg;
    parameter int CNT_W      = 8;
    parameter int NUM_PULSES = 4;
    parameter int CODE_W     = 3;
    parameter int ADDR_W     = 3;
    parameter int DATA_W     = 8;

    localparam int ADDR_PERIOD = 0;
    localparam int ADDR_ONTIME = 1;
    localparam int ADDR_ENABLE = 2;
    localparam int ADDR_CODE   = 3;
    localparam int ADDR_START  = 4;

    localparam logic [CODE_W-1:0] CODE_RESET = '1;

    typedef struct packed {
        logic [CNT_W-1:0]                      period;
        logic [CNT_W-1:0]                      ontime;
        logic [NUM_PULSES-1:0]                 enable;
        logic [NUM_PULSES-1:0][CNT_W-1:0]      start;
    } flash_cfg_t;
endpackage

// File: rtl/led_flash_regs.sv
module led_flash_regs
    import led_flash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_i,
    output flash_cfg_t        run_cfg_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        flash_cfg_t        shadow;
        flash_cfg_t        run;
        logic [CODE_W-1:0] code;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.run = s_q.shadow;
        end
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(ADDR_PERIOD)) s_d.shadow.period = wr_data_i[CNT_W-1:0];
            if (wr_addr_i == ADDR_W'(ADDR_ONTIME)) s_d.shadow.ontime = wr_data_i[CNT_W-1:0];
            if (wr_addr_i == ADDR_W'(ADDR_ENABLE)) s_d.shadow.enable = wr_data_i[NUM_PULSES-1:0];
            if (wr_addr_i == ADDR_W'(ADDR_CODE))   s_d.code          = wr_data_i[CODE_W-1:0];
            for (int i = 0; i < NUM_PULSES; i++) begin
                if (wr_addr_i == ADDR_W'(ADDR_START + i)) begin
                    s_d.shadow.start[i] = wr_data_i[CNT_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.code <= CODE_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_cfg_o = s_q.run;
    assign code_o    = s_q.code;

    // R6: the running set only moves on a load
    p_run_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(s_q.run));

    // R8: a code write is visible on the next clock
    p_code_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CODE)) |=> code_o == $past(wr_data_i[CODE_W-1:0]));
endmodule

// File: rtl/led_flash_counter.sv
module led_flash_counter
    import led_flash_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             idle;
    logic             at_end;

    always_comb begin
        idle   = (period_i == '0);
        at_end = (cnt_q == period_i - CNT_W'(1));
        load_o = tick_i && (idle || at_end);
        cnt_d  = cnt_q;
        if (tick_i) begin
            if (idle || at_end) cnt_d = '0;
            else                cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R2: no tick, no movement
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

    // R2: count never reaches a non-zero running period
    p_below_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0) |-> cnt_q < period_i);

    // R7: zero period pins the count
    p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |=> cnt_q == '0);
endmodule

// File: rtl/led_flash_window.sv
module led_flash_window
    import led_flash_pkg::*;
(
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] ontime_i,
    output logic             win_o
);
    logic [CNT_W:0] stop;

    always_comb begin
        stop  = {1'b0, start_i} + {1'b0, ontime_i};
        win_o = en_i && (cnt_i >= start_i) && ({1'b0, cnt_i} < stop);
    end
endmodule

// File: rtl/led_flash_gen.sv
module led_flash_gen
    import led_flash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic              pulse_on_o,
    output logic [2:0]        cur_code_o
);
    flash_cfg_t            run_cfg;
    logic [CNT_W-1:0]      cnt;
    logic                  load;
    logic [NUM_PULSES-1:0] win;

    led_flash_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load),
        .run_cfg_o (run_cfg),
        .code_o    (cur_code_o)
    );

    led_flash_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .period_i (run_cfg.period),
        .cnt_o    (cnt),
        .load_o   (load)
    );

    for (genvar g = 0; g < NUM_PULSES; g++) begin : g_pulse
        led_flash_window u_win (
            .en_i     (run_cfg.enable[g]),
            .cnt_i    (cnt),
            .start_i  (run_cfg.start[g]),
            .ontime_i (run_cfg.ontime),
            .win_o    (win[g])
        );
    end

    assign pulse_on_o = (|win) && (run_cfg.period != '0);

    // R7: a zero running period keeps the LED dark
    p_zero_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cfg.period == '0) |-> !pulse_on_o);

    // R4: output lit only through an enabled pulse
    p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_on_o |-> (run_cfg.enable != '0));

    // R1: reset state
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (!pulse_on_o || $isunknown(pulse_on_o));
        end
    end
endmodule

// File: tb/led_flash_gen_tb.sv
module led_flash_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       pulse_on_o;
    logic [2:0] cur_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    led_flash_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .pulse_on_o (pulse_on_o),
        .cur_code_o (cur_code_o)
    );

    // expected pulse flag after each of the first 12 ticks
    // P=10, on-time 2, starts 1,4,9 enabled, start 6 disabled
    localparam bit EXP_SEQ [12] = '{0,1,1,0,1,1,0,0,0,1,0,1};

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a negedge
    task automatic wr(input int addr, input int data);
        wr_en_i   = 1'b1;
        wr_addr_i = 3'(addr);
        wr_data_i = 8'(data);
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic tick1();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse", pulse_on_o, 0);
        chk("R1 code", cur_code_o, 7);
        tick1();
        chk("R1 unconfigured stays dark", pulse_on_o, 0);

        // R9 address map
        wr(0, 10);
        wr(1, 2);
        wr(2, 4'b0111);
        wr(4, 1);
        wr(5, 4);
        wr(6, 9);
        wr(7, 6);
        chk("R6 pending before tick", pulse_on_o, 0);

        // table walk: R3 R4 R5 R6
        for (int k = 0; k < 12; k++) begin
            tick1();
            chk($sformatf("R3 table step %0d", k), pulse_on_o, EXP_SEQ[k]);
        end

        // R2 no advance without tick (count 1, lit)
        repeat (5) @(negedge clk);
        chk("R2 hold without tick", pulse_on_o, 1);

        // pending on-time and period (count 1 now)
        wr(0, 4);
        wr(1, 1);
        tick1(); chk("R6 c2 old on-time", pulse_on_o, 1);
        wr(3, 2);
        chk("R8 code live", cur_code_o, 2);
        tick1(); chk("R8 pattern unaffected c3", pulse_on_o, 0);
        tick1(); chk("R8 pattern unaffected c4", pulse_on_o, 1);
        tick1(); chk("R6 old on-time still at c5", pulse_on_o, 1);
        tick1(); tick1(); tick1();
        tick1(); chk("R6 old period c9", pulse_on_o, 1);
        tick1(); chk("R5 wrap c0 dark", pulse_on_o, 0);
        tick1(); chk("R6 new c1", pulse_on_o, 1);
        tick1(); chk("R6 new on-time c2", pulse_on_o, 0);
        tick1(); chk("R2 c3", pulse_on_o, 0);
        tick1(); chk("R2 wrap at new period 4", pulse_on_o, 0);
        tick1(); chk("R2 c1 after wrap", pulse_on_o, 1);

        // zero period
        wr(0, 0);
        tick1(); tick1(); tick1();
        begin
            int lit = 0;
            for (int k = 0; k < 6; k++) begin
                tick1();
                if (pulse_on_o) lit++;
            end
            chk("R7 zero period dark", lit, 0);
        end
        wr(0, 4);
        tick1(); chk("R6 restart load c0", pulse_on_o, 0);
        tick1(); chk("R6 restart c1", pulse_on_o, 1);
        chk("R8 code kept", cur_code_o, 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule